// File: doc/BRIEF.md
# Nybble-Serial Register-File Datapath

This block carries out one 16-bit arithmetic or logic operation per start strobe, four bits at a time. Its four 16-bit registers sit in a small 16-entry, 4-bit-wide register memory. A 2-bit phase counter forms the low address bits, so one operation reads and writes the four nybbles of a register in four successive clock cycles. A carry flip-flop links each nybble to the next.

A controller outside the block sets an opcode, two source register numbers, a destination register number and, if needed, a 16-bit immediate that takes the place of the second source. It then pulses the start strobe. The result comes out as a stream of nybbles, least significant first, as each nybble is written back. A one-cycle done pulse follows the last nybble, and at that point the carry output holds the carry of the most significant nybble. The controller has no other access to the registers. It reads a register by running an operation whose result equals that register, such as XOR with an immediate of zero.

Top module: `nibser_datapath`

## Requirements
- R1: While reset is held and in the first cycle after it, done and result-valid are low and carry is 0. Every register reads back as 0x0000.
- R2: Opcode 2'b00 adds. The 16-bit sum goes to the destination, and carry gives the carry out of bit 15.
- R3: Opcode 2'b01 subtracts. The result is first operand plus the inverted second operand plus one, and carry is 1 exactly when the first operand is not less than the second.
- R4: Opcode 2'b10 writes the bitwise AND of the operands and gives carry 0.
- R5: Opcode 2'b11 writes the bitwise XOR of the operands and gives carry 0.
- R6: With the immediate select high, the 16-bit immediate sampled at start replaces the second source register.
- R7: Result-valid is high in the four cycles after an accepted start and low otherwise. In those cycles the result output presents bits [3:0], [7:4], [11:8], [15:12] in that order.
- R8: Done is high for exactly one cycle, the cycle after the fourth result nybble. Carry holds its final value until the next operation starts.
- R9: A start strobe during the four busy cycles is ignored. The running operation keeps the fields it sampled, and nothing is written to the register named by the ignored strobe.
- R10: The destination may be one of the sources. The in-place result equals the result computed from the old register values.
- R11: Register index bits form the upper memory address bits and the phase forms the lower two, so an operation leaves the other registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Starts an operation when the block is idle |
| op_i | input | 2 | Opcode: 00 add, 01 subtract, 10 AND, 11 XOR |
| src_a_i | input | 2 | First source register number |
| src_b_i | input | 2 | Second source register number |
| dst_i | input | 2 | Destination register number |
| imm_sel_i | input | 1 | Use the immediate as the second operand |
| imm_i | input | 16 | Immediate operand |
| res_nyb_o | output | 4 | Result nybble being written this cycle |
| res_vld_o | output | 1 | Result nybble valid |
| done_o | output | 1 | One-cycle pulse after the last nybble |
| carry_o | output | 1 | Registered carry; final carry once done |

## Verification
A phase counter that skips or repeats a value shows up within one operation: a nybble lands at the wrong address or the done pulse moves, and the next read-back of the register exposes it. A carry flip-flop with a stale or forced value corrupts the upper nybbles of an add or subtract in the same operation, and the wrong final carry is visible at the done pulse. Start fields that are not held correctly, or a start accepted while busy, corrupt the destination or another register. The next XOR-with-zero read of that register shows it, which in the sweep comes a few operations later.

// File: rtl/nibser_pkg.sv
// Shared opcode encoding for the nybble-serial datapath.
package nibser_pkg;
    typedef enum logic [1:0] {
        OP_ADD = 2'b00,
        OP_SUB = 2'b01,
        OP_AND = 2'b10,
        OP_XOR = 2'b11
    } alu_op_e;
endpackage

// File: rtl/nibser_alu.sv
// One-slice ALU: adds, subtracts (a + ~b + cin), ANDs or XORs two slices.
// Assumes the caller supplies the slice carry-in; the logic ops report carry 0.
module nibser_alu
    import nibser_pkg::*;
#(
    parameter int NYB_W = 4
) (
    input  alu_op_e          op,
    input  logic [NYB_W-1:0] a,
    input  logic [NYB_W-1:0] b,
    input  logic             cin,
    output logic [NYB_W-1:0] res,
    output logic             cout
);
    logic [NYB_W:0] sum;

    // Slice result and carry selected by opcode.
    always_comb begin
        sum  = '0;
        res  = '0;
        cout = 1'b0;
        unique case (op)
            OP_ADD: begin
                sum  = {1'b0, a} + {1'b0, b} + {{NYB_W{1'b0}}, cin};
                res  = sum[NYB_W-1:0];
                cout = sum[NYB_W];
            end
            OP_SUB: begin
                sum  = {1'b0, a} + {1'b0, ~b} + {{NYB_W{1'b0}}, cin};
                res  = sum[NYB_W-1:0];
                cout = sum[NYB_W];
            end
            OP_AND: res = a & b;
            OP_XOR: res = a ^ b;
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/nibser_regmem.sv
// Register memory: DEPTH entries of NYB_W bits, two combinational read ports
// and one synchronous write port. Cleared by synchronous reset.
// Assumes a read of the address being written returns the old value.
module nibser_regmem #(
    parameter int NYB_W = 4,
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [NYB_W-1:0] wdata,
    input  logic [AW-1:0]    raddr_a,
    input  logic [AW-1:0]    raddr_b,
    output logic [NYB_W-1:0] rdata_a,
    output logic [NYB_W-1:0] rdata_b
);
    logic [NYB_W-1:0] mem [DEPTH];

    // Clear on reset; otherwise write one entry when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Asynchronous reads for both operand ports.
    always_comb begin
        rdata_a = mem[raddr_a];
        rdata_b = mem[raddr_b];
    end

    // R11
    wr_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (mem[$past(waddr)] == $past(wdata)));
endmodule

// File: rtl/nibser_seq.sv
// Sequencer: accepts a start when idle, steps the phase through every slice
// from 0 upward, then pulses done once. Starts during busy are ignored.
module nibser_seq #(
    parameter int SLICES = 4,
    localparam int PH_W = $clog2(SLICES)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    output logic            accept_o,
    output logic            busy_o,
    output logic [PH_W-1:0] phase_o,
    output logic            last_o,
    output logic            done_o
);
    localparam logic [PH_W-1:0] LAST_PH = PH_W'(SLICES - 1);

    assign accept_o = start_i && !busy_o;
    assign last_o   = busy_o && (phase_o == LAST_PH);

    // Busy flag, phase counter and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_o  <= 1'b0;
            phase_o <= '0;
            done_o  <= 1'b0;
        end else begin
            done_o <= last_o;
            if (accept_o) begin
                busy_o  <= 1'b1;
                phase_o <= '0;
            end else if (busy_o) begin
                if (last_o) busy_o <= 1'b0;
                else        phase_o <= phase_o + 1'b1;
            end
        end
    end

    // R7
    phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !last_o) |=> (busy_o && phase_o == PH_W'($past(phase_o) + 1'b1)));
    // R9
    start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> (busy_o && phase_o == '0));
    // R8
    done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |=> (done_o && !busy_o));
    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
endmodule

// File: rtl/nibser_datapath.sv
// Nybble-serial datapath top. Samples the operation at start, then spends one
// cycle per slice: reads both sources at {reg, phase}, runs the slice ALU,
// writes the destination at the same phase and keeps the carry for the next
// slice. Assumes the controller waits for done before relying on carry_o.
module nibser_datapath
    import nibser_pkg::*;
#(
    parameter int NYB_W    = 4,
    parameter int SLICES   = 4,
    parameter int NUM_REGS = 4,
    localparam int WORD_W  = NYB_W * SLICES,
    localparam int PH_W    = $clog2(SLICES),
    localparam int RI_W    = $clog2(NUM_REGS),
    localparam int DEPTH   = NUM_REGS * SLICES,
    localparam int AW      = RI_W + PH_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [1:0]        op_i,
    input  logic [RI_W-1:0]   src_a_i,
    input  logic [RI_W-1:0]   src_b_i,
    input  logic [RI_W-1:0]   dst_i,
    input  logic              imm_sel_i,
    input  logic [WORD_W-1:0] imm_i,
    output logic [NYB_W-1:0]  res_nyb_o,
    output logic              res_vld_o,
    output logic              done_o,
    output logic              carry_o
);
    logic              accept, busy, last;
    logic [PH_W-1:0]   phase;
    alu_op_e           op_q;
    logic [RI_W-1:0]   src_a_q, src_b_q, dst_q;
    logic              imm_sel_q;
    logic [WORD_W-1:0] imm_q;
    logic              carry_q, cin, alu_cout;
    logic [NYB_W-1:0]  rd_a, rd_b, opnd_b, alu_res;
    logic [NYB_W-1:0]  imm_slice [SLICES];

    nibser_seq #(.SLICES(SLICES)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .accept_o (accept),
        .busy_o   (busy),
        .phase_o  (phase),
        .last_o   (last),
        .done_o   (done_o)
    );

    // Hold the operation fields for the whole sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q      <= OP_ADD;
            src_a_q   <= '0;
            src_b_q   <= '0;
            dst_q     <= '0;
            imm_sel_q <= 1'b0;
            imm_q     <= '0;
        end else if (accept) begin
            op_q      <= alu_op_e'(op_i);
            src_a_q   <= src_a_i;
            src_b_q   <= src_b_i;
            dst_q     <= dst_i;
            imm_sel_q <= imm_sel_i;
            imm_q     <= imm_i;
        end
    end

    nibser_regmem #(.NYB_W(NYB_W), .DEPTH(DEPTH)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (busy),
        .waddr   ({dst_q, phase}),
        .wdata   (alu_res),
        .raddr_a ({src_a_q, phase}),
        .raddr_b ({src_b_q, phase}),
        .rdata_a (rd_a),
        .rdata_b (rd_b)
    );

    // Split the immediate into slices for the phase-indexed multiplexer.
    for (genvar g = 0; g < SLICES; g++) begin : g_imm
        assign imm_slice[g] = imm_q[g*NYB_W +: NYB_W];
    end

    // Second operand source and slice carry-in.
    always_comb begin
        opnd_b = imm_sel_q ? imm_slice[phase] : rd_b;
        if (phase == '0) cin = (op_q == OP_SUB);
        else             cin = carry_q;
    end

    nibser_alu #(.NYB_W(NYB_W)) u_alu (
        .op   (op_q),
        .a    (rd_a),
        .b    (opnd_b),
        .cin  (cin),
        .res  (alu_res),
        .cout (alu_cout)
    );

    // Carry register: follows each slice, holds once idle.
    always_ff @(posedge clk) begin
        if (!rst_n)    carry_q <= 1'b0;
        else if (busy) carry_q <= alu_cout;
    end

    assign res_nyb_o = alu_res;
    assign res_vld_o = busy;
    assign carry_o   = carry_q;

    // R8
    carry_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !accept) |=> $stable(carry_o));
    // R4
    logic_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (op_q == OP_AND || op_q == OP_XOR)) |=> !carry_o);
endmodule

// File: tb/nibser_datapath_bench.sv
module nibser_datapath_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [1:0]  op_i = '0;
    logic [1:0]  src_a_i = '0, src_b_i = '0, dst_i = '0;
    logic        imm_sel_i = 1'b0;
    logic [15:0] imm_i = '0;
    logic [3:0]  res_nyb_o;
    logic        res_vld_o, done_o, carry_o;

    int checks = 0;
    int fails  = 0;
    logic [15:0] model [4] = '{default: 16'h0000};

    always #4 clk = ~clk;

    nibser_datapath u_nibser_datapath (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
        .src_a_i(src_a_i), .src_b_i(src_b_i), .dst_i(dst_i),
        .imm_sel_i(imm_sel_i), .imm_i(imm_i), .res_nyb_o(res_nyb_o),
        .res_vld_o(res_vld_o), .done_o(done_o), .carry_o(carry_o)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic string op_req(input logic [1:0] op);
        case (op)
            2'b00: return "R2";
            2'b01: return "R3";
            2'b10: return "R4";
            default: return "R5";
        endcase
    endfunction

    // One operation; optionally pulses an ignored start (XOR into r0) while busy.
    task automatic run_op(input logic [1:0] op, input int sa, input int sb,
                          input int d, input bit isel, input logic [15:0] imm,
                          input string req, input bit inject);
        logic [15:0] a, b, exp_r, got;
        logic [16:0] wide;
        logic        exp_c;
        a = model[sa];
        b = isel ? imm : model[sb];
        case (op)
            2'b00: begin wide = {1'b0, a} + {1'b0, b};              exp_r = wide[15:0]; exp_c = wide[16]; end
            2'b01: begin wide = {1'b0, a} + {1'b0, ~b} + 17'd1;     exp_r = wide[15:0]; exp_c = wide[16]; end
            2'b10: begin exp_r = a & b; exp_c = 1'b0; end
            default: begin exp_r = a ^ b; exp_c = 1'b0; end
        endcase
        @(negedge clk);
        op_i = op; src_a_i = 2'(sa); src_b_i = 2'(sb); dst_i = 2'(d);
        imm_sel_i = isel; imm_i = imm; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        if (inject) begin
            start_i = 1'b1; op_i = 2'b11; dst_i = 2'd0; src_a_i = 2'd1;
            imm_sel_i = 1'b1; imm_i = 16'hFFFF;
        end
        got = '0;
        for (int p = 0; p < 4; p++) begin
            if (p > 0) @(negedge clk);
            if (p == 1) start_i = 1'b0;
            check("R7", "result valid during slice", 32'(res_vld_o), 32'd1);
            got[p*4 +: 4] = res_nyb_o;
        end
        @(negedge clk);
        check("R8", "done after last slice", 32'(done_o), 32'd1);
        check("R7", "valid low after slices", 32'(res_vld_o), 32'd0);
        check(req, "result word", 32'(got), 32'(exp_r));
        check(req, "final carry", 32'(carry_o), 32'(exp_c));
        @(negedge clk);
        check("R8", "done single cycle", 32'(done_o), 32'd0);
        check("R8", "carry held", 32'(carry_o), 32'(exp_c));
        model[d] = exp_r;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [15:0] vals [8];
        vals = '{16'h0000, 16'h0001, 16'h000F, 16'hFFFF,
                 16'h8000, 16'h7FFF, 16'h1234, 16'hF0F1};
        repeat (3) @(negedge clk);
        // R1: outputs during reset
        check("R1", "done in reset", 32'(done_o), 32'd0);
        check("R1", "valid in reset", 32'(res_vld_o), 32'd0);
        check("R1", "carry in reset", 32'(carry_o), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "done after reset", 32'(done_o), 32'd0);
        check("R1", "carry after reset", 32'(carry_o), 32'd0);
        // R1: every register reads zero (XOR in place with immediate 0)
        for (int r = 0; r < 4; r++) run_op(2'b11, r, r, r, 1'b1, 16'h0000, "R1", 1'b0);

        for (int i = 0; i < 8; i++) begin
            for (int j = 0; j < 8; j++) begin
                run_op(2'b00, 0, 0, 1, 1'b1, vals[i], "R6", 1'b0);
                run_op(2'b00, 0, 0, 2, 1'b1, vals[j], "R6", 1'b0);
                for (int op = 0; op < 4; op++) begin
                    run_op(2'(op), 1, 2, 3, 1'b0, 16'h0000, op_req(2'(op)), 1'b0);
                    run_op(2'(op), 1, 0, 3, 1'b1, vals[j], "R6", 1'b0);
                end
                // R11: sources untouched by writes to r3
                run_op(2'b11, 1, 0, 1, 1'b1, 16'h0000, "R11", 1'b0);
                run_op(2'b11, 2, 0, 2, 1'b1, 16'h0000, "R11", 1'b0);
                // R10: in-place destination equals a source
                run_op(2'((i + j) % 4), 2, 1, 2, 1'b0, 16'h0000, "R10", 1'b0);
                run_op(2'b00, 1, 1, 1, 1'b0, 16'h0000, "R10", 1'b0);
            end
        end

        // R9: start while busy is ignored; r0 must stay zero
        run_op(2'b00, 0, 0, 1, 1'b1, 16'hA5C3, "R6", 1'b0);
        run_op(2'b01, 1, 0, 2, 1'b1, 16'h0F0F, "R9", 1'b1);
        run_op(2'b11, 0, 0, 0, 1'b1, 16'h0000, "R9", 1'b0);
        run_op(2'b11, 2, 0, 2, 1'b1, 16'h0000, "R9", 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule